// File: doc/BRIEF.md
# Edge-Selectable Input Port Interrupt Controller

This peripheral serves a small 4-bit microcontroller. It watches eight input pins, arranged as two groups of four. Software can read each group's pin levels. It chooses per pin whether that pin takes part in interrupt generation and whether a rising or a falling edge counts. Each group has one mask bit and one factor flag.

Each pin passes through a two-stage synchronizer. An edge is found by comparing the synchronized level with its value one cycle earlier. When a selected pin shows its chosen edge, the group's factor flag sets, whether or not the group is masked. Reading the flag returns its value and clears it. Each group drives one interrupt request line, which is high while both the flag and the mask are set.

The CPU side is a nibble-wide register bus. Read data is combinational while the read strobe is high. Writes and read-clears take effect at the next rising clock edge.

Top module: `kport_irq`

## Requirements
- R1: Reading address 91h (group 0, pins 3..0) or 95h (group 1, pins 7..4) returns the synchronized pin levels, 1 for high and 0 for low. A pin change is visible two clock edges after it is presented. Writes to these addresses change nothing.
- R2: The edge-polarity registers sit at 92h (group 0) and 96h (group 1). Bit n=1 selects a falling edge for pin n of the group, and 0 selects a rising edge. They are readable and reset to 1111.
- R3: The edge-select registers sit at 90h (group 0) and 94h (group 1). Only a pin whose select bit is 1 can set its group's flag. They are readable and reset to 0000.
- R4: A selected pin that shows its chosen edge sets the group flag (group 0 at FBh, group 1 at FAh, both in D0). This happens whatever the mask value, at the third rising edge after the pin change is presented.
- R5: A read of a flag address returns the flag and clears it at the following edge. Writes to the flag addresses are ignored. A qualifying edge in the same cycle as the read leaves the flag set.
- R6: The mask bits sit at F3h (group 0) and F2h (group 1) in D0, are readable, and reset to 0. irq_o[g] is high exactly while group g's flag and mask are both 1.
- R7: Unused data bits, unmapped addresses and any cycle without bus_rd read as 0. Both flags reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Raw input pins; bits 3..0 are group 0, bits 7..4 are group 1 |
| bus_addr | input | 8 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data, 0 when not reading |
| irq_o | output | 2 | Per-group interrupt request level |

## Verification
The bench builds the block with its default parameters: two groups of four pins, an 8-bit address, a two-stage synchronizer, and the register bases at 90h, F3h and FBh. With these values both groups are in play. This covers the ascending per-group register blocks as well as the descending mask and flag addresses. Pin edges and flag reads can be placed in the same cycle, and the fixed three-edge latency from pin to flag can be compared against a model on every clock.

// File: rtl/kport_irq.sv
module kport_irq #(
  parameter int GROUPS   = 2,
  parameter int WIDTH    = 4,
  parameter int AW       = 8,
  parameter int SYNC     = 2,
  parameter int SEL_BASE = 'h90,
  parameter int STRIDE   = 4,
  parameter int MASK_TOP = 'hF3,
  parameter int FLAG_TOP = 'hFB
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [GROUPS*WIDTH-1:0] pin_i,
  input  logic [AW-1:0]           bus_addr,
  input  logic                    bus_rd,
  input  logic                    bus_wr,
  input  logic [WIDTH-1:0]        bus_wdata,
  output logic [WIDTH-1:0]        bus_rdata,
  output logic [GROUPS-1:0]       irq_o
);
  localparam int NB = GROUPS * WIDTH;

  logic [NB-1:0] sync_q [SYNC];
  logic [NB-1:0] lvl, prev_q, rise, fall, sel_q, pol_q, hit;
  logic [GROUPS-1:0] mask_q, flag_q, grp_ev, rd_flag, wr_flag;
  logic [WIDTH-1:0] grp_rd [GROUPS];
  logic [WIDTH-1:0] rd_or;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC; i++) sync_q[i] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= pin_i;
      for (int i = 1; i < SYNC; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[SYNC-1];
    end
  end

  assign lvl  = sync_q[SYNC-1];
  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
  assign hit  = sel_q & ((pol_q & fall) | (~pol_q & rise));

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam logic [AW-1:0] A_SEL = AW'(SEL_BASE + g*STRIDE);
    localparam logic [AW-1:0] A_DAT = AW'(SEL_BASE + g*STRIDE + 1);
    localparam logic [AW-1:0] A_POL = AW'(SEL_BASE + g*STRIDE + 2);
    localparam logic [AW-1:0] A_MSK = AW'(MASK_TOP - g);
    localparam logic [AW-1:0] A_FLG = AW'(FLAG_TOP - g);

    assign grp_ev[g]  = |hit[g*WIDTH +: WIDTH];
    assign rd_flag[g] = bus_rd && (bus_addr == A_FLG);
    assign wr_flag[g] = bus_wr && (bus_addr == A_FLG);
    assign irq_o[g]   = flag_q[g] & mask_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[g*WIDTH +: WIDTH] <= '0;
        pol_q[g*WIDTH +: WIDTH] <= '1;
        mask_q[g] <= 1'b0;
        flag_q[g] <= 1'b0;
      end else begin
        if (bus_wr && bus_addr == A_SEL) sel_q[g*WIDTH +: WIDTH] <= bus_wdata;
        if (bus_wr && bus_addr == A_POL) pol_q[g*WIDTH +: WIDTH] <= bus_wdata;
        if (bus_wr && bus_addr == A_MSK) mask_q[g] <= bus_wdata[0];
        flag_q[g] <= grp_ev[g] | (flag_q[g] & ~rd_flag[g]);
      end
    end

    always_comb begin
      grp_rd[g] = '0;
      if (bus_addr == A_SEL) grp_rd[g] = sel_q[g*WIDTH +: WIDTH];
      if (bus_addr == A_DAT) grp_rd[g] = lvl[g*WIDTH +: WIDTH];
      if (bus_addr == A_POL) grp_rd[g] = pol_q[g*WIDTH +: WIDTH];
      if (bus_addr == A_MSK) grp_rd[g] = {{(WIDTH-1){1'b0}}, mask_q[g]};
      if (bus_addr == A_FLG) grp_rd[g] = {{(WIDTH-1){1'b0}}, flag_q[g]};
    end

    p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      grp_ev[g] |=> flag_q[g]);
    p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q[g] && !grp_ev[g]) |=> !flag_q[g]);
    p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_flag[g] && !grp_ev[g]) |=> !flag_q[g]);
    p_clear_only_by_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[g] && !rd_flag[g]) |=> flag_q[g]);
    p_write_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_flag[g] && !bus_rd && !grp_ev[g]) |=> flag_q[g] == $past(flag_q[g]));
    p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!mask_q[g] && !(bus_wr && bus_addr == A_MSK)) |=> !irq_o[g]);
  end

  always_comb begin
    rd_or = '0;
    for (int g = 0; g < GROUPS; g++) rd_or = rd_or | grp_rd[g];
  end

  assign bus_rdata = bus_rd ? rd_or : '0;

  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == '0);
endmodule

// File: tb/kport_irq_tb.sv
module kport_irq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_i = '0;
  logic [7:0] bus_addr = '0;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [3:0] bus_wdata = '0;
  logic [3:0] bus_rdata;
  logic [1:0] irq_o;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  bit [3:0] m_sel [2];
  bit [3:0] m_pol [2];
  bit       m_msk [2];
  bit       m_flg [2];
  bit [7:0] hist [$];

  always #2 clk = ~clk;

  kport_irq u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  function automatic bit [3:0] exp_read();
    bit [3:0] v = 4'h0;
    if (!bus_rd) return 4'h0;
    for (int g = 0; g < 2; g++) begin
      if (bus_addr == 8'(8'h90 + 4*g)) v = m_sel[g];
      if (bus_addr == 8'(8'h91 + 4*g)) v = hist[1][4*g +: 4];
      if (bus_addr == 8'(8'h92 + 4*g)) v = m_pol[g];
      if (bus_addr == 8'(8'hF3 - g))   v = {3'b000, m_msk[g]};
      if (bus_addr == 8'(8'hFB - g))   v = {3'b000, m_flg[g]};
    end
    return v;
  endfunction

  task automatic model_reset();
    hist = '{8'h00, 8'h00, 8'h00};
    for (int g = 0; g < 2; g++) begin
      m_sel[g] = 4'h0; m_pol[g] = 4'hF; m_msk[g] = 1'b0; m_flg[g] = 1'b0;
    end
  endtask

  task automatic step(input bit [7:0] a, input bit rd, input bit wr,
                      input bit [3:0] wd, input bit [7:0] pins, input string req);
    bit [3:0] er;
    bit [1:0] ei;
    bit [7:0] lv, pv;
    pin_i = pins; bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd;
    #1;
    er = exp_read();
    ei = {m_flg[1] & m_msk[1], m_flg[0] & m_msk[0]};
    vectors++;
    if (bus_rdata !== er || irq_o !== ei) begin
      fails++;
      $display("FAIL %s addr=%h rdata=%h irq=%b expected rdata=%h irq=%b",
               req, a, bus_rdata, irq_o, er, ei);
    end
    @(posedge clk);
    lv = hist[1]; pv = hist[2];
    for (int g = 0; g < 2; g++) begin
      bit ev = 1'b0;
      for (int b = 0; b < 4; b++) begin
        bit r = lv[4*g+b] && !pv[4*g+b];
        bit f = !lv[4*g+b] && pv[4*g+b];
        if (m_sel[g][b] && (m_pol[g][b] ? f : r)) ev = 1'b1;
      end
      if (rd && a == 8'(8'hFB - g)) m_flg[g] = 1'b0;
      if (ev) m_flg[g] = 1'b1;
      if (wr && a == 8'(8'h90 + 4*g)) m_sel[g] = wd;
      if (wr && a == 8'(8'h92 + 4*g)) m_pol[g] = wd;
      if (wr && a == 8'(8'hF3 - g))   m_msk[g] = wd[0];
    end
    hist.push_front(pins);
    void'(hist.pop_back());
    @(negedge clk);
  endtask

  task automatic idle(input int n, input bit [7:0] pins, input string req);
    for (int i = 0; i < n; i++) step(8'h00, 1'b0, 1'b0, 4'h0, pins, req);
  endtask

  task automatic rd(input bit [7:0] a, input bit [7:0] pins, input string req);
    step(a, 1'b1, 1'b0, 4'h0, pins, req);
  endtask

  task automatic wr(input bit [7:0] a, input bit [3:0] d, input bit [7:0] pins, input string req);
    step(a, 1'b0, 1'b1, d, pins, req);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 R3 R6 R7 reset values and unmapped reads
    rd(8'h92, 8'h00, "R2"); rd(8'h96, 8'h00, "R2");
    rd(8'h90, 8'h00, "R3"); rd(8'h94, 8'h00, "R3");
    rd(8'hF3, 8'h00, "R6"); rd(8'hF2, 8'h00, "R6");
    rd(8'hFB, 8'h00, "R7"); rd(8'hFA, 8'h00, "R7");
    rd(8'h80, 8'h00, "R7"); rd(8'h93, 8'h00, "R7");
    // R1 pin levels and latency
    step(8'h91, 1'b1, 1'b0, 4'h0, 8'hA5, "R1");
    rd(8'h91, 8'hA5, "R1"); rd(8'h91, 8'hA5, "R1"); rd(8'h95, 8'hA5, "R1");
    wr(8'h91, 4'h0, 8'hA5, "R1"); rd(8'h91, 8'hA5, "R1");
    // R3 unselected bits toggle: no flag
    idle(4, 8'h5A, "R3"); rd(8'hFB, 8'h5A, "R3"); rd(8'hFA, 8'h5A, "R3");
    // R2 R4 group 0 bit 0 rising, masked
    wr(8'h92, 4'h0, 8'h00, "R2"); rd(8'h92, 8'h00, "R2");
    wr(8'h90, 4'h1, 8'h00, "R3"); idle(3, 8'h00, "R4");
    idle(4, 8'h01, "R4"); rd(8'hFB, 8'h01, "R4"); rd(8'hFB, 8'h01, "R5");
    // R6 unmask then edge
    wr(8'hF3, 4'h1, 8'h01, "R6");
    idle(4, 8'h00, "R2"); idle(4, 8'h01, "R6");
    wr(8'hFB, 4'h0, 8'h01, "R5"); idle(2, 8'h01, "R6");
    rd(8'hFB, 8'h01, "R5"); idle(2, 8'h01, "R6");
    // unselected bit 1 toggles
    idle(4, 8'h03, "R3"); idle(4, 8'h01, "R3");
    // group 1 bit 1 falling (reset polarity)
    wr(8'h94, 4'h2, 8'h21, "R3"); wr(8'hF2, 4'h1, 8'h21, "R6");
    idle(3, 8'h21, "R2"); idle(5, 8'h01, "R2"); rd(8'hFA, 8'h01, "R5");
    // R5 edge coincident with read: every alignment
    for (int k = 0; k < 6; k++) begin
      idle(k, 8'h21, "R5");
      for (int j = 0; j < 6; j++) rd(8'hFA, 8'h01, "R5");
      idle(4, 8'h21, "R5");
    end
    // R4 R5 R6 random traffic
    for (int i = 0; i < 600; i++) begin
      bit [7:0] a;
      case ($urandom % 12)
        0: a = 8'h90; 1: a = 8'h91; 2: a = 8'h92; 3: a = 8'h94;
        4: a = 8'h95; 5: a = 8'h96; 6: a = 8'hF2; 7: a = 8'hF3;
        8: a = 8'hFA; 9: a = 8'hFB; 10: a = 8'h93; default: a = 8'h7F;
      endcase
      case ($urandom % 3)
        0: step(a, 1'b1, 1'b0, 4'h0, 8'($urandom), "R4");
        1: step(a, 1'b0, 1'b1, 4'($urandom), 8'($urandom), "R5");
        default: step(a, 1'b0, 1'b0, 4'h0, 8'($urandom), "R6");
      endcase
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule